// File: doc/BRIEF.md
# Page Write Collector with Stop-Time Commit

This block sits between a serial bus engine and a byte-wide nonvolatile array. Once the engine has decoded a write address, it opens a page session. Each data byte the engine accepts is dropped into a local page buffer at a running offset. That offset wraps inside the page, so the page number never moves. A bit per offset records which bytes were actually loaded during the session.

When the engine reports a stop, the block decides whether to keep the session. A stop that lands on a byte-plus-acknowledge boundary, after at least one complete byte, commits the session. Any other stop throws it away. A commit starts a timed internal write cycle that holds `busy` high for a parameter-set number of clocks. In the last page-length slots of that cycle, the block replays every loaded offset to the array write port, in ascending order. While `busy` is high, every bus-side input is ignored.

Top module: `page_commit_buffer`

## Requirements
- R1: After a synchronous reset, `busy` and `arr_we` are both low.
- R2: An accepted byte is stored at the current offset, and only the low log2(PAGE_BYTES) address bits then increment. Every array write of a session carries the page number taken from `page_addr` at `page_open`, in `arr_addr[ADDR_W-1:OFF_W]`, with the offset in the low bits.
- R3: The offset wraps from PAGE_BYTES-1 to 0 within the same page. With 64-byte pages, 64 bytes loaded from offset 32 fill 32..63 and then 0..31, and a 65th byte lands on offset 32 again.
- R4: When more than a page of bytes is sent, each byte replaces whatever was loaded earlier at the same offset, so only the last value per offset reaches the array.
- R5: A stop with `stop_on_boundary`=1, after at least one accepted byte, commits the session and raises `busy` on the same clock edge that samples the stop.
- R6: A stop with `stop_on_boundary`=0 discards the session: `busy` stays low and the array receives no write.
- R7: A stop with `stop_on_boundary`=1 but no accepted byte since `page_open` discards the session, with no busy and no write.
- R8: A commit writes exactly one array entry per offset loaded in the session, and no other offset of the page.
- R9: `busy` is high for WR_CLKS+1 clocks. The writes occupy the final PAGE_BYTES slots of that window, and `busy` falls on the edge that takes the last write.
- R10: While `busy` is high, `page_open`, `byte_valid` and `stop_pulse` have no effect. This holds both for array contents and for later busy cycles.
- R11: A new `page_open` clears the loaded-byte record and the buffered page. After a stop, bytes and stops that arrive before the next `page_open` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| page_open | input | 1 | One-clock strobe: start a session at `page_addr` |
| page_addr | input | ADDR_W | Page number (high bits) and starting offset (low bits) |
| byte_valid | input | 1 | One-clock strobe: a data byte was accepted |
| byte_data | input | 8 | Data byte qualified by `byte_valid` |
| stop_pulse | input | 1 | One-clock strobe: stop condition seen |
| stop_on_boundary | input | 1 | Stop arrived right after a full byte plus acknowledge |
| arr_we | output | 1 | Array write enable (registered) |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The bench keeps the default 64-byte page and 15-bit address, but lowers WR_CLKS to 72. With that setting, a full write cycle is short enough to measure exactly after every commit, while the scan window still covers every offset of the page. This makes reachable, within a few thousand clocks, the mid-page wrap, a 140-byte overflow, partial rewrites over a prefilled page, and strobes injected in the middle of a busy window. A byte-accurate model of the array is compared against the writes the block produces.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int unsigned PCB_DATA_W = 8;
  typedef logic [PCB_DATA_W-1:0] pcb_byte_t;
endpackage

// File: rtl/pcb_page_ram.sv
module pcb_page_ram #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  pcb_pkg::pcb_byte_t wdata,
  input  logic [AW-1:0]      raddr,
  output pcb_pkg::pcb_byte_t rdata
);
  pcb_pkg::pcb_byte_t mem [DEPTH];

  // simple dual-port, synchronous read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pcb_loader.sv
module pcb_loader #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned ADDR_W     = 15,
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W  = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  busy,
  input  logic                  page_open,
  input  logic [ADDR_W-1:0]     page_addr,
  input  logic                  byte_valid,
  input  pcb_pkg::pcb_byte_t    byte_data,
  input  logic                  stop_pulse,
  input  logic                  stop_on_boundary,
  output logic [PG_W-1:0]       page_q,
  output logic [PAGE_BYTES-1:0] vmask,
  output logic                  buf_we,
  output logic [OFF_W-1:0]      buf_waddr,
  output pcb_pkg::pcb_byte_t    buf_wdata,
  output logic                  commit
);
  logic             armed;
  logic [OFF_W-1:0] off_q;
  logic             take_open, take_stop;

  // priority inside one clock: open > stop > byte; all gated by busy
  always_comb begin
    take_open = !busy && page_open;
    take_stop = !busy && !page_open && stop_pulse && armed;
    buf_we    = !busy && !page_open && !stop_pulse && byte_valid && armed;
    commit    = take_stop && stop_on_boundary && (|vmask);
    buf_waddr = off_q;
    buf_wdata = byte_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      off_q  <= '0;
      page_q <= '0;
      vmask  <= '0;
    end else if (take_open) begin
      armed  <= 1'b1;
      page_q <= page_addr[ADDR_W-1:OFF_W];
      off_q  <= page_addr[OFF_W-1:0];
      vmask  <= '0;
    end else if (take_stop) begin
      armed <= 1'b0;
      if (!commit) vmask <= '0;
    end else if (buf_we) begin
      vmask[off_q] <= 1'b1;
      off_q        <= off_q + 1'b1;   // wraps inside the page
    end
  end
endmodule

// File: rtl/pcb_writer.sv
module pcb_writer #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned WR_CLKS    = 1000,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W      = ADDR_W - OFF_W,
  localparam int unsigned TW        = $clog2(WR_CLKS + 1),
  localparam int unsigned SCAN_BASE = WR_CLKS - PAGE_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commit,
  input  logic [PG_W-1:0]       page_q,
  input  logic [PAGE_BYTES-1:0] vmask,
  output logic [OFF_W-1:0]      rd_off,
  input  pcb_pkg::pcb_byte_t    rd_data,
  output logic                  arr_we,
  output logic [ADDR_W-1:0]     arr_addr,
  output pcb_pkg::pcb_byte_t    arr_wdata,
  output logic                  busy
);
  logic [TW-1:0] timer;
  logic          in_scan;

  always_comb begin
    in_scan   = busy && (timer >= TW'(SCAN_BASE)) && (timer < TW'(WR_CLKS));
    rd_off    = OFF_W'(timer - TW'(SCAN_BASE));
    arr_wdata = rd_data;   // RAM output register lines up with arr_we
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      timer    <= '0;
      arr_we   <= 1'b0;
      arr_addr <= '0;
    end else begin
      arr_we   <= in_scan && vmask[rd_off];
      arr_addr <= {page_q, rd_off};
      if (!busy) begin
        if (commit) begin
          busy  <= 1'b1;
          timer <= '0;
        end
      end else if (timer == TW'(WR_CLKS)) begin
        busy  <= 1'b0;
        timer <= '0;
      end else begin
        timer <= timer + 1'b1;
      end
    end
  end
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned WR_CLKS    = 1000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               page_open,
  input  logic [ADDR_W-1:0]  page_addr,
  input  logic               byte_valid,
  input  logic [7:0]         byte_data,
  input  logic               stop_pulse,
  input  logic               stop_on_boundary,
  output logic               arr_we,
  output logic [ADDR_W-1:0]  arr_addr,
  output logic [7:0]         arr_wdata,
  output logic               busy
);
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES);
  localparam int unsigned PG_W  = ADDR_W - OFF_W;

  logic [PG_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0] vmask;
  logic                  buf_we, commit;
  logic [OFF_W-1:0]      buf_waddr, rd_off;
  pcb_pkg::pcb_byte_t    buf_wdata, rd_data;

  pcb_loader #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_loader (
    .clk(clk), .rst(rst), .busy(busy),
    .page_open(page_open), .page_addr(page_addr),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .stop_pulse(stop_pulse), .stop_on_boundary(stop_on_boundary),
    .page_q(page_q), .vmask(vmask),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .commit(commit)
  );

  pcb_page_ram #(.DEPTH(PAGE_BYTES)) u_ram (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(rd_off), .rdata(rd_data)
  );

  pcb_writer #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .WR_CLKS(WR_CLKS)) u_writer (
    .clk(clk), .rst(rst), .commit(commit), .page_q(page_q), .vmask(vmask),
    .rd_off(rd_off), .rd_data(rd_data),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy)
  );
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned ADDR_W     = 15,
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  arr_we,
  input logic [ADDR_W-1:0]     arr_addr,
  input logic                  stop_pulse,
  input logic                  stop_on_boundary,
  input logic [PAGE_BYTES-1:0] vmask
);
  assert_we_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  assert_we_loaded_R8: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> vmask[arr_addr[OFF_W-1:0]]);

  assert_page_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |->
      (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])));

  assert_commit_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_pulse && stop_on_boundary));

  assert_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(|vmask));

  assert_mask_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(vmask));
endmodule

bind page_commit_buffer pcb_checker #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
  .stop_pulse(stop_pulse), .stop_on_boundary(stop_on_boundary), .vmask(vmask)
);

// File: tb/page_commit_buffer_test.sv
`timescale 1ns/1ps
module page_commit_buffer_test;
  localparam int PB = 64;
  localparam int AW = 15;
  localparam int WR = 72;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic page_open = 1'b0, byte_valid = 1'b0, stop_pulse = 1'b0, stop_on_boundary = 1'b0;
  logic [AW-1:0] page_addr = '0;
  logic [7:0] byte_data = '0;
  logic arr_we, busy;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [7:0] dut_mem [int];
  logic [7:0] ref_mem [int];
  int s_page, s_off;
  logic [7:0] s_buf [PB];
  logic [PB-1:0] s_load;

  always #2.5 clk = ~clk;

  page_commit_buffer #(.PAGE_BYTES(PB), .ADDR_W(AW), .WR_CLKS(WR)) uut (
    .clk(clk), .rst(rst), .page_open(page_open), .page_addr(page_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .stop_pulse(stop_pulse),
    .stop_on_boundary(stop_on_boundary), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .busy(busy)
  );

  always @(posedge clk) if (!rst && arr_we) begin
    dut_mem[int'(arr_addr)] = arr_wdata;
    wr_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rd_dut(input int a);
    return dut_mem.exists(a) ? int'(dut_mem[a]) : 0;
  endfunction
  function automatic int rd_ref(input int a);
    return ref_mem.exists(a) ? int'(ref_mem[a]) : 0;
  endfunction

  task automatic cmp_page(input int pg, input string tag);
    int bad = -1;
    for (int i = 0; i < PB; i++)
      if (bad < 0 && rd_dut(pg*PB+i) != rd_ref(pg*PB+i)) bad = i;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, {tag, " array byte"}, rd_dut(pg*PB+bad), rd_ref(pg*PB+bad));
  endtask

  task automatic drv_open(input int pg, input int off);
    @(negedge clk); page_open = 1'b1; page_addr = AW'(pg*PB + off);
    @(negedge clk); page_open = 1'b0;
  endtask
  task automatic drv_byte(input logic [7:0] d);
    @(negedge clk); byte_valid = 1'b1; byte_data = d;
    @(negedge clk); byte_valid = 1'b0;
  endtask
  task automatic drv_stop(input bit clean);
    @(negedge clk); stop_pulse = 1'b1; stop_on_boundary = clean;
    @(negedge clk); stop_pulse = 1'b0; stop_on_boundary = 1'b0;
  endtask

  task automatic s_open(input int pg, input int off);
    s_page = pg; s_off = off; s_load = '0;
    drv_open(pg, off);
  endtask
  task automatic s_byte(input logic [7:0] d);
    s_buf[s_off] = d; s_load[s_off] = 1'b1; s_off = (s_off + 1) % PB;
    drv_byte(d);
  endtask
  // stop, update the model, measure busy and the number of writes
  task automatic s_stop(input bit clean, input string tag);
    int w0 = wr_cnt, cnt = 0;
    bit commits = clean && (|s_load);
    drv_stop(clean);
    if (commits)
      for (int i = 0; i < PB; i++) if (s_load[i]) ref_mem[s_page*PB+i] = s_buf[i];
    while (busy && cnt < 10*WR) begin cnt++; @(negedge clk); end
    repeat (3) @(negedge clk);
    if (commits) check(cnt == WR+1, {tag, " R9 busy length"}, cnt, WR+1);
    else         check(cnt == 0, {tag, " R6/R7 no busy on discard"}, cnt, 0);
    check(wr_cnt - w0 == $countones(s_load) * int'(commits),
          {tag, " R8 write count"}, wr_cnt - w0, $countones(s_load) * int'(commits));
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(arr_we == 1'b0, "R1 arr_we after reset", int'(arr_we), 0);
  endtask

  task automatic t_single();
    s_open(9'h1AB, 5); s_byte(8'h5A); s_stop(1'b1, "single R5");
    cmp_page(9'h1AB, "R2 R5 single byte at offset");
  endtask

  task automatic t_wrap();
    s_open(3, 32);
    for (int i = 0; i < 65; i++) s_byte(8'(i*3 + 1));
    s_stop(1'b1, "wrap R3");
    cmp_page(3, "R3 wrap from offset 32");
    check(rd_dut(3*PB+32) == 64*3+1, "R3 65th byte at offset 32", rd_dut(3*PB+32), 64*3+1);
  endtask

  task automatic t_overflow();
    s_open(7, 60);
    for (int i = 0; i < 140; i++) s_byte(8'(i ^ 8'hA5));
    s_stop(1'b1, "overflow R4");
    cmp_page(7, "R4 overflow overwrites");
  endtask

  task automatic t_abort_mid();
    s_open(9, 0);
    for (int i = 0; i < PB; i++) s_byte(8'(8'h40 + i));
    s_stop(1'b1, "prefill");
    s_open(9, 0); s_byte(8'h11); s_byte(8'h22); s_byte(8'h33);
    s_stop(1'b0, "abort mid R6");
    cmp_page(9, "R6 array untouched after mid-byte stop");
  endtask

  task automatic t_abort_empty();
    s_open(9, 20);
    s_stop(1'b1, "abort empty R7");
    cmp_page(9, "R7 array untouched after empty stop");
  endtask

  task automatic t_partial();
    s_open(9, 10);
    for (int i = 0; i < 4; i++) s_byte(8'(8'hC0 + i));
    s_stop(1'b1, "partial R8");
    cmp_page(9, "R8 only loaded offsets change");
  endtask

  task automatic t_busy_ignore();
    int w0, cnt = 0;
    s_open(12, 0); s_byte(8'h77);
    for (int i = 0; i < PB; i++) if (s_load[i]) ref_mem[12*PB+i] = s_buf[i];
    w0 = wr_cnt;
    drv_stop(1'b1);
    drv_open(12, 1); drv_byte(8'hEE); drv_byte(8'hEF); drv_stop(1'b1);
    check(busy == 1'b1, "R10 still busy during injected strobes", int'(busy), 1);
    while (busy) @(negedge clk);
    repeat (4) begin @(negedge clk); if (busy) cnt++; end
    check(cnt == 0, "R10 no second write cycle", cnt, 0);
    check(wr_cnt - w0 == 1, "R10 write count", wr_cnt - w0, 1);
    cmp_page(12, "R10 strobes during busy ignored");
  endtask

  task automatic t_reopen();
    int cnt = 0, w0;
    s_open(20, 0); s_byte(8'h01); s_byte(8'h02); s_byte(8'h03);
    s_open(21, 4); s_byte(8'h99);
    s_stop(1'b1, "reopen R11");
    cmp_page(20, "R11 abandoned page untouched");
    cmp_page(21, "R11 reopened page written");
    w0 = wr_cnt;
    drv_byte(8'h55); drv_stop(1'b1);
    repeat (6) begin @(negedge clk); if (busy) cnt++; end
    check(cnt == 0 && wr_cnt == w0, "R11 out-of-session stop ignored", cnt, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_overflow();
    t_abort_mid();
    t_abort_empty();
    t_partial();
    t_busy_ignore();
    t_reopen();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule